// File: doc/BRIEF.md
# GPIO bank with interrupt detection

This block is one bank of sixteen general-purpose pins with a 32-bit register interface. Software picks each pin's direction and drives output values through a data register. A separate per-pin mask decides which pins a data access may reach. Input pins are synchronised with two flops and then pass through a per-pin input enable, so they are observed only when software asks for it.

Every pin can raise an interrupt. Three independent per-pin bits select the detection: sense (level or edge), both-edge, and polarity. Edge events are held in a latch until software writes a one to the matching bit of the clear register. Level conditions follow the pin live. The raw status is ANDed with the per-pin enable to form the masked status. The OR of the masked status bits leaves the bank as a single registered interrupt line. The bank decodes address bits 6:0 only, so banks can be placed 0x80 bytes apart.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads zero, `pad_oe`, `pad_out` and `irq` are zero, and no status is pending.
- R2: A write to the data register (0x00) changes only the pins whose bit is set in the access mask (0x04). A read of 0x00 returns zero for every pin whose mask bit is clear.
- R3: `pad_oe` equals the direction register (0x08, 1 = output), and `pad_out` carries the data bit of each output pin and zero for every input pin.
- R4: A data read returns the data bit for an output pin. For an input pin it returns the synchronised pad value when the input-enable bit (0x28) is set, and zero when it is clear. A pad change can be read after the second rising edge and not after the first.
- R5: With sense (0x0C) = 0 and both-edge (0x10) = 0, a rising edge latches the raw status bit (0x1C) when polarity (0x14) = 1, and a falling edge latches it when polarity = 0. The opposite edge leaves the bit unchanged.
- R6: With sense = 0 and both-edge = 1, either edge latches the raw status bit, whatever the polarity bit holds.
- R7: With sense = 1, the raw status bit follows the enabled input live: it equals the input when polarity = 1 and its inverse when polarity = 0. A write to the clear register has no effect on it.
- R8: Writing 1 to a bit of the clear register (0x24) clears that pin's latched edge status. A 0 bit leaves it untouched.
- R9: The masked status (0x20) equals raw status AND interrupt enable (0x18). Clearing an enable bit does not lose the raw status.
- R10: `irq` is the OR of the masked status bits, delayed by one clock.
- R11: Bits 31:16 of every register read zero. The clear register and any unused offset read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte offset inside the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Pad input values, asynchronous |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach from the ports is all eight detection configurations running at once while the pads move, clears arrive and enables change. The latched state then depends on the whole history of each pin. The bench gives each pin one of the eight sense/both-edge/polarity combinations, so every combination sits on two pins, and drives a pseudo-random pad sequence that includes repeated (unchanged) vectors. Between pad steps it inserts partial clears and enable changes. It predicts raw status, masked status and `irq` after every step with an arithmetic model of the requirements.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPIN = 16,
  parameter int AW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq
);
  localparam logic [AW-1:0] A_DATA = AW'('h00);
  localparam logic [AW-1:0] A_DMSK = AW'('h04);
  localparam logic [AW-1:0] A_DIR  = AW'('h08);
  localparam logic [AW-1:0] A_SNS  = AW'('h0C);
  localparam logic [AW-1:0] A_BTH  = AW'('h10);
  localparam logic [AW-1:0] A_POL  = AW'('h14);
  localparam logic [AW-1:0] A_IEN  = AW'('h18);
  localparam logic [AW-1:0] A_RAW  = AW'('h1C);
  localparam logic [AW-1:0] A_MIS  = AW'('h20);
  localparam logic [AW-1:0] A_CLR  = AW'('h24);
  localparam logic [AW-1:0] A_INEN = AW'('h28);
  localparam int PADW = 32 - NPIN;

  logic [NPIN-1:0] data_q, dmsk_q, dir_q, sns_q, bth_q, pol_q, ien_q, inen_q;
  logic [NPIN-1:0] lat_q, s1_q, s2_q, prv_q;
  logic            irq_q;

  logic [NPIN-1:0] wr_n, in_w, rise_w, fall_w, hit_w, lvl_w, raw_w, mis_w;
  logic [NPIN-1:0] clr_w, rd_pin_w, rd_w;

  assign wr_n   = bus_wdata[NPIN-1:0];
  assign in_w   = s2_q & inen_q;
  assign rise_w = in_w & ~prv_q;
  assign fall_w = prv_q & ~in_w;
  assign hit_w  = ~sns_q & ((bth_q & (rise_w | fall_w)) |
                            (~bth_q & pol_q & rise_w) |
                            (~bth_q & ~pol_q & fall_w));
  assign lvl_w  = (pol_q & in_w) | (~pol_q & ~in_w);
  assign raw_w  = (sns_q & lvl_w) | (~sns_q & lat_q);
  assign mis_w  = raw_w & ien_q;
  assign clr_w  = (bus_we && bus_addr == A_CLR) ? wr_n : '0;

  assign pad_oe  = dir_q;
  assign pad_out = data_q & dir_q;
  assign irq     = irq_q;

  assign rd_pin_w = ((dir_q & data_q) | (~dir_q & in_w)) & dmsk_q;

  always_comb begin
    case (bus_addr)
      A_DATA:  rd_w = rd_pin_w;
      A_DMSK:  rd_w = dmsk_q;
      A_DIR:   rd_w = dir_q;
      A_SNS:   rd_w = sns_q;
      A_BTH:   rd_w = bth_q;
      A_POL:   rd_w = pol_q;
      A_IEN:   rd_w = ien_q;
      A_RAW:   rd_w = raw_w;
      A_MIS:   rd_w = mis_w;
      A_INEN:  rd_w = inen_q;
      default: rd_w = '0;
    endcase
  end

  assign bus_rdata = {{PADW{1'b0}}, rd_w};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; dmsk_q <= '0; dir_q <= '0; sns_q <= '0;
      bth_q  <= '0; pol_q  <= '0; ien_q <= '0; inen_q <= '0;
      lat_q  <= '0; s1_q   <= '0; s2_q  <= '0; prv_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      s1_q  <= pad_in;
      s2_q  <= s1_q;
      prv_q <= in_w;
      lat_q <= ((lat_q & ~clr_w) | hit_w) & ~sns_q;
      irq_q <= |mis_w;
      if (bus_we) begin
        case (bus_addr)
          A_DATA: data_q <= (data_q & ~dmsk_q) | (wr_n & dmsk_q);
          A_DMSK: dmsk_q <= wr_n;
          A_DIR:  dir_q  <= wr_n;
          A_SNS:  sns_q  <= wr_n;
          A_BTH:  bth_q  <= wr_n;
          A_POL:  pol_q  <= wr_n;
          A_IEN:  ien_q  <= wr_n;
          A_INEN: inen_q <= wr_n;
          default: ;
        endcase
      end
    end
  end
endmodule

module gpio_bank_chk #(
  parameter int NPIN = 16,
  parameter int AW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [NPIN-1:0] data_q,
  input logic [NPIN-1:0] dmsk_q,
  input logic [NPIN-1:0] lat_q,
  input logic [NPIN-1:0] hit_w,
  input logic [NPIN-1:0] mis_w,
  input logic            irq
);
  localparam logic [AW-1:0] A_CLR = AW'('h24);

  a_r10_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|mis_w) |=> irq);
  a_r10_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(|mis_w) |=> !irq);
  a_r2_mask_guard: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(data_q)) & ~$past(dmsk_q)) == '0));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR) |=>
      ((lat_q & $past(bus_wdata[NPIN-1:0]) & ~$past(hit_w)) == '0));
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & ~$past(lat_q) & ~$past(hit_w)) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .data_q(data_q), .dmsk_q(dmsk_q), .lat_q(lat_q),
  .hit_w(hit_w), .mis_w(mis_w), .irq(irq)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  gpio_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [15:0] sns, bth, pol, ien, lat, v, o, lf, rise, fall, hit, lvl, raw, m;

    idle(3);
    rst_n = 1'b1;
    idle(1);
    for (int a = 0; a < 64; a += 4) begin
      rd(7'(a), rv);
      chk("R1 reset read", rv, 0);
    end
    chk("R1 reset pads", {pad_oe, pad_out}, 0);
    chk("R1 reset irq", {31'b0, irq}, 0);

    wr(7'h04, 32'h0000_00FF);
    wr(7'h08, 32'hFFFF_FFFF);
    rd(7'h08, rv);
    chk("R11 upper bits", rv, 32'h0000_FFFF);
    wr(7'h00, 32'hFFFF_FFFF);
    chk("R2 masked write pad_out", {16'b0, pad_out}, 32'h0000_00FF);
    chk("R3 pad_oe follows dir", {16'b0, pad_oe}, 32'h0000_FFFF);
    rd(7'h00, rv);
    chk("R2 read data", rv, 32'h0000_00FF);
    wr(7'h04, 32'h0000_0F00);
    rd(7'h00, rv);
    chk("R2 read masked off", rv, 0);
    wr(7'h00, 32'h0000_FFFF);
    chk("R2 second masked write", {16'b0, pad_out}, 32'h0000_0FFF);
    wr(7'h04, 32'h0000_FFFF);
    wr(7'h08, 32'h0000_00F0);
    chk("R3 pad_out only outputs", {16'b0, pad_out}, 32'h0000_00F0);
    rd(7'h24, rv);
    chk("R11 clear reads zero", rv, 0);
    rd(7'h2C, rv);
    chk("R11 unused reads zero", rv, 0);

    wr(7'h08, 32'h0000_0F00);
    wr(7'h28, 32'h0000_00F0);
    pad_in = 16'hFFFF;
    idle(3);
    rd(7'h00, rv);
    chk("R4 input enable and output readback", rv, 32'h0000_0FF0);
    wr(7'h08, 32'h0);
    wr(7'h28, 32'h0000_FFFF);
    pad_in = 16'h0000;
    idle(4);
    @(negedge clk);
    pad_in = 16'h0001;
    @(negedge clk);
    rd(7'h00, rv);
    chk("R4 one edge not yet visible", rv, 0);
    @(negedge clk);
    rd(7'h00, rv);
    chk("R4 visible after two edges", rv, 1);
    pad_in = 16'h0000;
    idle(4);

    sns = '0; bth = '0; pol = '0;
    for (int p = 0; p < 16; p++) begin
      sns[p] = p[2]; bth[p] = p[1]; pol[p] = p[0];
    end
    ien = 16'hFFFF;
    wr(7'h14, {16'b0, pol});
    wr(7'h10, {16'b0, bth});
    wr(7'h0C, {16'b0, sns});
    wr(7'h18, {16'b0, ien});
    wr(7'h24, 32'h0000_FFFF);
    idle(2);
    lat = '0; v = '0; lf = 16'hACE1;
    lvl = ~v & ~pol | v & pol;
    raw = (sns & lvl) | (~sns & lat);
    rd(7'h1C, rv);
    chk("R7 level start", rv, {16'b0, raw});

    for (int s = 0; s < 60; s++) begin
      o = v;
      if (s % 5 != 4) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        v = lf;
      end
      pad_in = v;
      idle(4);
      rise = v & ~o; fall = o & ~v;
      hit = ~sns & ((bth & (rise | fall)) | (~bth & pol & rise) | (~bth & ~pol & fall));
      lat = lat | hit;
      lvl = (pol & v) | (~pol & ~v);
      raw = (sns & lvl) | (~sns & lat);
      rd(7'h1C, rv);
      chk("R5 R6 R7 raw after pad step", rv, {16'b0, raw});
      rd(7'h20, rv);
      chk("R9 masked status", rv, {16'b0, raw & ien});
      chk("R10 irq", {31'b0, irq}, {31'b0, |(raw & ien)});

      if (s % 6 == 5) begin
        m = 16'h5A5A ^ 16'(s * 16'h0111);
        wr(7'h24, {16'hFFFF, m});
        idle(1);
        lat = lat & ~m;
        raw = (sns & lvl) | (~sns & lat);
        rd(7'h1C, rv);
        chk("R8 R7 after clear", rv, {16'b0, raw});
        chk("R10 irq after clear", {31'b0, irq}, {31'b0, |(raw & ien)});
      end
      if (s % 7 == 6) begin
        ien = ~ien ^ 16'(s * 16'h0203);
        wr(7'h18, {16'b0, ien});
        idle(1);
        rd(7'h1C, rv);
        chk("R9 raw kept across enable change", rv, {16'b0, raw});
        rd(7'h20, rv);
        chk("R9 masked after enable change", rv, {16'b0, raw & ien});
        chk("R10 irq after enable change", {31'b0, irq}, {31'b0, |(raw & ien)});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule